// File: doc/BRIEF.md
# Serial Peripheral Port with Write-Collision Detection

This block is one SPI channel that a processor drives through two registers: a control register that holds the setup fields and the status flags, and a data register that holds the byte to send or the byte last received. The channel runs as a bus master or as a slave. As master it divides the system clock to make SCK. As slave it follows an external SCK, after first bringing that clock into the system clock domain.

Bytes are shifted MSB first through an internal shift buffer. A received byte reaches the readable data register only after its last bit has arrived. A finished frame sets a completion flag, and that flag is also the interrupt request. Three build-time parameters set the variant: which SCK edge samples the data, whether a write-collision flag exists, and whether a chip-select line qualifies the transfer. When the port is switched off, it releases every line it drives.

Control register layout (write through `wr_sel=0`, read through `rd_sel=0`):
- bit 0: port on
- bit 1: master mode
- bits 3:2: clock divider select
- bit 4: reads 0
- bit 5: write-collision flag (writing 0 clears it)
- bit 6: frame-done flag (writing 0 clears it)
- bit 7: busy, read-only

Top module: `spi_port`

## Requirements
- R1: After reset, the control register reads 0x00, the data register reads 0x00, `irq` is low and `sck_oe`, `sdo_oe` and `scs_oe` are all low.
- R2: In master mode (control bits 0 and 1 set), a data-register write while not busy starts a frame. `sdo` presents the byte MSB first. The byte assembled MSB first from `sdi` appears in the data register only at the end of the frame; until then the register keeps its previous value.
- R3: With divider select s in control bits 3:2, each SCK half period lasts 2^s system clocks, so `irq` rises exactly 16·2^s clocks after the edge that took the data write.
- R4: With the default sampling option (`SAMPLE_RISE=1`), SCK idles low. `sdi` is sampled on the rising edge and `sdo` changes on the falling edge, in both master and slave mode.
- R5: A finished frame sets control bit 6 and `irq`. Either a pulse on `irq_ack` or a control write with bit 6 at 0 clears it.
- R6: With `WCOL_EN=1`, a data-register write while busy (control bit 7) sets control bit 5 and leaves the frame in progress intact. A control write with bit 5 at 0 clears the flag.
- R7: While control bit 0 is 0, `sck_oe`, `sdo_oe` and `scs_oe` are low. Clearing bit 0 during a frame ends the frame with no completion flag.
- R8: In slave mode (bit 0 set, bit 1 clear), `sck_oe` is low. The port shifts on the external `sck_i`, drives `sdo` while `scs_i` is low, and receives a full byte from it.
- R9: With `CS_EN=1`, a slave with `scs_i` high ignores `sck_i`: busy stays 0, no frame completes and the data register is unchanged.
- R10: With `CS_EN=1`, a rising `scs_i` in the middle of a slave byte aborts the frame and resets the bit counter. The aborted frame raises no completion flag, and the next full frame is received correctly.
- R11: With `CS_EN=1` in master mode, `scs_oe` is high and `scs_o` is low exactly while a frame is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 data |
| wr_data | input | DW | Write value |
| rd_sel | input | 1 | Read source: 0 control, 1 data |
| rd_data | output | DW | Read value (combinational) |
| irq | output | 1 | Frame-done interrupt request |
| irq_ack | input | 1 | Interrupt service acknowledge, clears the request |
| sck_i | input | 1 | External clock in slave mode |
| sck_o | output | 1 | Generated clock in master mode |
| sck_oe | output | 1 | Clock output enable |
| scs_i | input | 1 | Chip-select input, active low |
| scs_o | output | 1 | Chip-select output, active low |
| scs_oe | output | 1 | Chip-select output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Data output enable |

## Verification
The assertions assume that `sck_i` and `scs_i` change slowly compared with the system clock, so that the two-flop synchronizer sees each level for at least several cycles. They also assume that the mode bit is not changed while a frame is running. The stimulus holds every external clock level for six system clocks and changes the control register only between frames, with one exception: the port-off write in the R7 test, whose outcome the assertions allow for. In master tests, the bench changes `sdi` only on the falling SCK, well away from the sampling edge.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DW          = 8,
  parameter bit SAMPLE_RISE = 1'b1,
  parameter bit WCOL_EN     = 1'b1,
  parameter bit CS_EN       = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  input  logic          irq_ack,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          scs_i,
  output logic          scs_o,
  output logic          scs_oe,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe
);
  localparam int  CW   = $clog2(DW + 1);
  localparam int  HCW  = 4;
  localparam logic IDLE = SAMPLE_RISE ? 1'b0 : 1'b1;

  logic          en, mst, wcol, trf, busy, samp, sck_r;
  logic [1:0]    div;
  logic [DW-1:0] sh, rx;
  logic [CW-1:0] bits;
  logic [HCW-1:0] cnt;
  logic [2:0]    sck_sy, scs_sy;

  wire cwr = wr_en && !wr_sel;
  wire dwr = wr_en && wr_sel;
  wire collide = dwr && busy;

  wire [HCW-1:0] half_m1 = (HCW'(1) << div) - HCW'(1);
  wire m_tick  = en && mst && busy && (cnt == half_m1);
  wire m_lead  = m_tick && (sck_r == IDLE);
  wire m_trail = m_tick && (sck_r != IDLE);

  wire s_sel   = !CS_EN || !scs_sy[1];
  wire s_edge  = en && !mst && s_sel && (sck_sy[1] != sck_sy[2]);
  wire s_lead  = s_edge && (sck_sy[1] != IDLE);
  wire s_trail = s_edge && (sck_sy[1] == IDLE) && busy;
  wire s_abort = CS_EN && en && !mst && scs_sy[1] && !scs_sy[2];

  wire lead  = m_lead || s_lead;
  wire trail = m_trail || s_trail;
  wire last  = trail && (bits == CW'(DW - 1));
  wire [DW-1:0] sh_next = {sh[DW-2:0], samp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= {3{IDLE}};
      scs_sy <= 3'b111;
    end else begin
      sck_sy <= {sck_sy[1:0], sck_i};
      scs_sy <= {scs_sy[1:0], scs_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; mst <= 1'b0; div <= '0;
      wcol <= 1'b0; trf <= 1'b0; busy <= 1'b0;
      samp <= 1'b0; sck_r <= IDLE;
      sh <= '0; rx <= '0; bits <= '0; cnt <= '0;
    end else begin
      if (cwr) begin
        en  <= wr_data[0];
        mst <= wr_data[1];
        div <= wr_data[3:2];
      end
      if (WCOL_EN && collide) wcol <= 1'b1;
      else if (cwr && !wr_data[5]) wcol <= 1'b0;
      if (last) trf <= 1'b1;
      else if (irq_ack || (cwr && !wr_data[6])) trf <= 1'b0;
      if (dwr && !busy) sh <= wr_data;
      if (!en || s_abort) begin
        busy  <= 1'b0;
        bits  <= '0;
        cnt   <= '0;
        sck_r <= IDLE;
      end else begin
        if (dwr && !busy && mst) begin
          busy <= 1'b1;
          cnt  <= '0;
          bits <= '0;
        end else if (mst && busy) begin
          cnt <= m_tick ? '0 : cnt + 1'b1;
        end
        if (m_tick) sck_r <= ~sck_r;
        if (lead) begin
          samp <= sdi;
          busy <= 1'b1;
        end
        if (trail) begin
          sh   <= sh_next;
          bits <= last ? '0 : bits + 1'b1;
          if (last) begin
            rx   <= sh_next;
            busy <= 1'b0;
          end
        end
      end
    end
  end

  wire [7:0] ctrl_v = {busy, trf, wcol, 1'b0, div, mst, en};

  assign rd_data = rd_sel ? rx : DW'(ctrl_v);
  assign irq     = trf;
  assign sck_o   = sck_r;
  assign sck_oe  = en && mst;
  assign scs_o   = !(mst && busy);
  assign scs_oe  = CS_EN && en && mst;
  assign sdo     = sh[DW-1];
  assign sdo_oe  = en && (mst || s_sel);
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int DW          = 8,
  parameter bit SAMPLE_RISE = 1'b1,
  parameter bit WCOL_EN     = 1'b1,
  parameter bit CS_EN       = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          mst,
  input logic          busy,
  input logic          trf,
  input logic          wcol,
  input logic          last,
  input logic          collide,
  input logic          irq_ack,
  input logic [DW-1:0] rx,
  input logic [3:0]    bits,
  input logic          scs_s,
  input logic          scs_q,
  input logic          sck_o,
  input logic          sck_oe,
  input logic          sdo_oe,
  input logic          scs_oe
);
  localparam logic IDLE = SAMPLE_RISE ? 1'b0 : 1'b1;

  // R7
  port_off_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!sck_oe && !sdo_oe && !scs_oe));

  // R8
  slave_sck_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mst) |-> !sck_oe);

  // R6
  collision_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (WCOL_EN && collide) |=> wcol);

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !last) |=> !trf);

  // R2
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(rx));

  // R9
  cs_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CS_EN && en && !mst && scs_s && scs_q) |=> $stable(bits));

  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mst && !busy) |-> (sck_o == IDLE));
endmodule

bind spi_port spi_port_chk #(
  .DW(DW), .SAMPLE_RISE(SAMPLE_RISE), .WCOL_EN(WCOL_EN), .CS_EN(CS_EN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mst(mst), .busy(busy), .trf(trf),
  .wcol(wcol), .last(last), .collide(collide), .irq_ack(irq_ack), .rx(rx),
  .bits(4'(bits)), .scs_s(scs_sy[1]), .scs_q(scs_sy[2]), .sck_o(sck_o),
  .sck_oe(sck_oe), .sdo_oe(sdo_oe), .scs_oe(scs_oe)
);

// File: tb/sim_spi_port.sv
`timescale 1ns/1ps
module sim_spi_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0, irq_ack = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic irq, sck_o, sck_oe, scs_o, scs_oe, sdo, sdo_oe, sdi;
  logic sck_in = 1'b0, scs_in = 1'b1, s_sdi = 1'b0, use_mst = 1'b0;
  logic [7:0] rep_r = 0, mosi = 0;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  spi_port u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq), .irq_ack(irq_ack),
    .sck_i(sck_in), .sck_o(sck_o), .sck_oe(sck_oe), .scs_i(scs_in),
    .scs_o(scs_o), .scs_oe(scs_oe), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  assign sdi = use_mst ? rep_r[7] : s_sdi;
  always @(posedge sck_o) if (use_mst) mosi <= {mosi[6:0], sdo};
  always @(negedge sck_o) if (use_mst) rep_r <= {rep_r[6:0], 1'b0};

  // {tx, reply, divider select}
  localparam logic [17:0] VEC [6] = '{
    {8'hA5, 8'h3C, 2'd0}, {8'h01, 8'h80, 2'd1}, {8'hFF, 8'h00, 2'd2},
    {8'h00, 8'hFF, 2'd3}, {8'h6E, 8'hC9, 2'd0}, {8'h81, 8'h7E, 2'd2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    rd_sel = sel; #1 v = rd_data;
  endtask

  task automatic wait_irq(output int cyc);
    cyc = 0;
    while (!irq && cyc < 5000) begin @(negedge clk); cyc++; end
  endtask

  task automatic sbits(input logic [7:0] rep, input int nb, output logic [7:0] got);
    got = 0;
    for (int i = 7; i > 7 - nb; i--) begin
      s_sdi = rep[i];
      repeat (6) @(negedge clk);
      got[i] = sdo;
      sck_in = 1'b1;
      repeat (6) @(negedge clk);
      sck_in = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] v, got;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, v); check("R1 ctrl reset", v, 8'h00);
    rd(1, v); check("R1 data reset", v, 8'h00);
    check("R1 irq/oe reset", {irq, sck_oe, sdo_oe, scs_oe}, 4'b0000);

    use_mst = 1'b1;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] tx, rp; logic [1:0] dv;
      {tx, rp, dv} = VEC[i];
      wr(0, 8'h03 | {4'd0, dv, 2'd0});
      check("R4 master idle sck low", {sck_oe, sck_o}, 2'b10);
      check("R11 scs idle high", {scs_oe, scs_o}, 2'b11);
      rep_r = rp; mosi = 0;
      @(negedge clk); wr_en = 1; wr_sel = 1; wr_data = tx;
      @(negedge clk); wr_en = 0;
      wait_irq(cyc);
      check("R3 frame length", cyc, 16 << dv);
      check("R2 mosi MSB first", mosi, tx);
      rd(1, v); check("R2 received byte", v, rp);
      rd(0, v); check("R5 done flag set", {v[7], v[6]}, 2'b01);
      ack();
      check("R5 irq cleared by ack", irq, 1'b0);
    end

    wr(0, 8'h0B); rep_r = 8'h3C; mosi = 0;
    wr(1, 8'h96);
    repeat (10) @(negedge clk);
    rd(0, v); check("R6 busy during frame", v[7], 1'b1);
    rd(1, v); check("R2 data held mid frame", v, 8'h7E);
    check("R11 scs low in frame", {scs_oe, scs_o}, 2'b10);
    wr(1, 8'h00);
    rd(0, v); check("R6 collision flag", v[5], 1'b1);
    wait_irq(cyc);
    check("R6 frame intact mosi", mosi, 8'h96);
    rd(1, v); check("R6 frame intact rx", v, 8'h3C);
    check("R11 scs high after", scs_o, 1'b1);
    wr(0, 8'h0B);
    rd(0, v); check("R6 R5 flags cleared by write", {v[6], v[5]}, 2'b00);
    check("R5 irq low after write", irq, 1'b0);

    wr(0, 8'h0F); rep_r = 8'hAA;
    wr(1, 8'h55);
    repeat (20) @(negedge clk);
    wr(0, 8'h00);
    check("R7 lines floated", {sck_oe, sdo_oe, scs_oe}, 3'b000);
    repeat (200) @(negedge clk);
    rd(0, v); check("R7 frame ended no flag", {v, irq}, 9'h000);

    use_mst = 1'b0;
    wr(0, 8'h01);
    repeat (4) @(negedge clk);
    check("R8 slave sck float", sck_oe, 1'b0);
    check("R8 sdo off when deselected", sdo_oe, 1'b0);
    wr(1, 8'hC3);
    scs_in = 1'b0; repeat (4) @(negedge clk);
    check("R8 sdo driven when selected", sdo_oe, 1'b1);
    sbits(8'h5A, 8, got);
    check("R8 slave sdo MSB first", got, 8'hC3);
    check("R8 slave irq", irq, 1'b1);
    rd(1, v); check("R8 slave received", v, 8'h5A);
    ack();

    scs_in = 1'b1; repeat (4) @(negedge clk);
    sbits(8'hF0, 8, got);
    rd(0, v); check("R9 ignored sck busy", v[7], 1'b0);
    check("R9 no irq", irq, 1'b0);
    rd(1, v); check("R9 data unchanged", v, 8'h5A);

    wr(1, 8'h0F);
    scs_in = 1'b0; repeat (4) @(negedge clk);
    sbits(8'hFF, 3, got);
    scs_in = 1'b1; repeat (6) @(negedge clk);
    rd(0, v); check("R10 abort clears busy", v[7], 1'b0);
    check("R10 abort no irq", irq, 1'b0);
    wr(1, 8'h0F);
    scs_in = 1'b0; repeat (4) @(negedge clk);
    sbits(8'hE7, 8, got);
    check("R10 next frame sdo", got, 8'h0F);
    check("R10 next frame irq", irq, 1'b1);
    rd(1, v); check("R10 next frame received", v, 8'hE7);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule